// File: doc/BRIEF.md
# Two-Bit Age Replacement Engine

This block chooses which way of a set-associative cache to replace. Each way of each set carries a two-bit age. A lower age means the line was used more recently. The surrounding cache controller presents one access per cycle, made up of a strobe, the set index, whether the lookup hit, the way that hit, and the per-way valid bits of that set taken from its tag array. The engine returns, with no register delay, the way that a miss on that set should fill.

The engine updates the ages of the indexed set on the clock edge that samples the strobe. A hit moves the touched line toward age zero. A miss writes the new line into the victim way at age one. After either kind of access, every age in the set is raised by the same amount, so that at least one line sits at the maximum age of three. As a result, a line at age three always exists whenever every way is valid. While a set still has empty ways, they fill in order from way zero upward. Tags, data storage and coherence are handled elsewhere.

Top module: `age_repl_engine`

## Requirements
- R1: After reset, every age of every set is 3. With all ways valid, every set reports victim way 0.
- R2: When at least one bit of `way_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, whatever the ages are.
- R3: When all ways are valid, `victim_way` is the lowest-numbered way of the indexed set whose age is 3.
- R4: A miss access, meaning a strobe with `acc_hit` = 0, writes age 1 into the way that `victim_way` showed in that cycle, before the uniform aging of R6 is applied.
- R5: A hit access sets the age of `acc_hit_way` to 1 if it was 2 or 3, and to 0 if it was 1 or 0, before the uniform aging of R6 is applied.
- R6: After the change made by R4 or R5, every age in the set is raised by the same amount. The result has at least one age equal to 3, and the order of the ages is unchanged.
- R7: An access changes only the ages of the set selected by `acc_set`. Every other set keeps its ages.
- R8: Ages change only on a rising clock edge at which `acc_valid` is 1. Without the strobe, changes on `acc_set`, `acc_hit`, `acc_hit_way` and `way_valid` leave the stored ages as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Set index of the access, and the set that `victim_way` reports on |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| acc_hit_way | input | WAY_W | Way that hit, used only when `acc_hit` is 1 |
| way_valid | input | NUM_WAYS | Valid bit of each way of the indexed set |
| victim_way | output | WAY_W | Way to fill on a miss, taken from the registered ages of `acc_set` |

## Verification
The hardest state to reach from the ports is a set in which the uniform raise leaves the ages spread out, for example one line at 2 and the others at 3, so that the victim is not simply way 0. The stimulus gets there in a fixed order. It fills a set through misses and promotes one line with hits while the others are still young. The final fill then collapses the set and exposes the offset. A long pseudo-random run of hits and misses over several fully valid sets follows. It is compared at every miss against a bench model that raises the ages one step at a time until some way reaches 3.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;
    localparam int AGE_W = 2;
    typedef logic [AGE_W-1:0] age_t;
    localparam age_t AGE_MAX    = 2'd3;
    localparam age_t AGE_INSERT = 2'd1;
    localparam age_t AGE_NEAR   = 2'd1;
    localparam age_t AGE_NEWEST = 2'd0;
endpackage

// File: rtl/age_victim_pick.sv
module age_victim_pick
    import age_repl_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  age_t [NUM_WAYS-1:0] ages_i,
    input  logic [NUM_WAYS-1:0] valid_i,
    output logic [WAY_W-1:0]    victim_o
);
    logic             empty_found;
    logic [WAY_W-1:0] empty_idx;
    logic [WAY_W-1:0] oldest_idx;

    // Scan from the top down so that the lowest match is written last
    always_comb begin
        empty_found = 1'b0;
        empty_idx   = '0;
        oldest_idx  = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                empty_found = 1'b1;
                empty_idx   = WAY_W'(w);
            end
            if (ages_i[w] == AGE_MAX) begin
                oldest_idx = WAY_W'(w);
            end
        end
        victim_o = empty_found ? empty_idx : oldest_idx;
    end
endmodule

// File: rtl/age_set_update.sv
module age_set_update
    import age_repl_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  age_t [NUM_WAYS-1:0] ages_i,
    input  logic                is_hit_i,
    input  logic [WAY_W-1:0]    hit_way_i,
    input  logic [WAY_W-1:0]    fill_way_i,
    output age_t [NUM_WAYS-1:0] ages_o
);
    age_t [NUM_WAYS-1:0] touched;
    age_t                peak;
    age_t                lift;

    // Promote the hit line or place the new line
    always_comb begin
        touched = ages_i;
        if (is_hit_i) begin
            if (ages_i[hit_way_i] <= AGE_NEAR) begin
                touched[hit_way_i] = AGE_NEWEST;
            end else begin
                touched[hit_way_i] = AGE_NEAR;
            end
        end else begin
            touched[fill_way_i] = AGE_INSERT;
        end
    end

    // Find the oldest age left in the set
    always_comb begin
        peak = AGE_NEWEST;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (touched[w] > peak) begin
                peak = touched[w];
            end
        end
        lift = AGE_MAX - peak;
    end

    // Raise every way at once, same as repeating +1 until one way is at the maximum
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_lift
        assign ages_o[g] = touched[g] + lift;
    end
endmodule

// File: rtl/age_repl_engine.sv
module age_repl_engine
    import age_repl_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int NUM_SETS = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [SET_W-1:0]    acc_set,
    input  logic                acc_hit,
    input  logic [WAY_W-1:0]    acc_hit_way,
    input  logic [NUM_WAYS-1:0] way_valid,
    output logic [WAY_W-1:0]    victim_way
);
    typedef age_t [NUM_WAYS-1:0] set_ages_t;

    typedef struct packed {
        set_ages_t [NUM_SETS-1:0] ages;
        logic [SET_W-1:0]         fill_set;
        logic [WAY_W-1:0]         fill_way;
    } state_t;

    state_t    state_d, state_q;
    set_ages_t rd_ages;
    set_ages_t wr_ages;
    logic [WAY_W-1:0] pick_way;

    assign rd_ages    = state_q.ages[acc_set];
    assign victim_way = pick_way;

    age_victim_pick #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_pick (
        .ages_i   (rd_ages),
        .valid_i  (way_valid),
        .victim_o (pick_way)
    );

    age_set_update #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_update (
        .ages_i     (rd_ages),
        .is_hit_i   (acc_hit),
        .hit_way_i  (acc_hit_way),
        .fill_way_i (pick_way),
        .ages_o     (wr_ages)
    );

    always_comb begin
        state_d          = state_q;
        state_d.fill_set = acc_set;
        state_d.fill_way = pick_way;
        if (acc_valid) begin
            state_d.ages[acc_set] = wr_ages;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    state_q.ages[s][w] <= AGE_MAX;
                end
            end
            state_q.fill_set <= '0;
            state_q.fill_way <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R2: an empty way is always preferred as the victim
    assert_empty_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (way_valid != '1) |-> !way_valid[victim_way])
        else $error("victim is a valid way while an empty way exists");

    // R3: with a full set the victim carries the maximum age
    assert_victim_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (way_valid == '1) |-> (rd_ages[victim_way] == AGE_MAX))
        else $error("victim is not at the maximum age");

    // R4: a filled line never ends up as the newest line
    assert_fill_not_newest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> (state_q.ages[state_q.fill_set][state_q.fill_way] != AGE_NEWEST))
        else $error("filled line stored at age 0");

    // R8: no strobe, no change of any age
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(state_q.ages))
        else $error("ages changed without an access strobe");

    // R6: every set always holds at least one line at the maximum age
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                assert_has_oldest_R6: assert (|{state_q.ages[s]} && (state_q.ages[s] != '0)
                    && (NUM_WAYS'(0) != oldest_mask(state_q.ages[s])))
                    else $error("set %0d has no line at the maximum age", s);
            end
        end
    end

    function automatic logic [NUM_WAYS-1:0] oldest_mask(input set_ages_t a);
        logic [NUM_WAYS-1:0] m;
        for (int w = 0; w < NUM_WAYS; w++) begin
            m[w] = (a[w] == AGE_MAX);
        end
        return m;
    endfunction
endmodule

// File: tb/age_repl_engine_bench.sv
module age_repl_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [3:0]    acc_set = '0;
    logic          acc_hit = 1'b0;
    logic [3:0]    acc_hit_way = '0;
    logic [NW-1:0] way_valid = '0;
    logic [3:0]    victim_way;

    int checks = 0;
    int errors = 0;
    int model [NS][NW];
    logic [NW-1:0] vmask [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    age_repl_engine u_age_repl_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_set     (acc_set),
        .acc_hit     (acc_hit),
        .acc_hit_way (acc_hit_way),
        .way_valid   (way_valid),
        .victim_way  (victim_way)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: victim actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_victim(input int s);
        for (int w = 0; w < NW; w++) if (!vmask[s][w]) return w;
        for (int w = 0; w < NW; w++) if (model[s][w] == 3) return w;
        return -1;
    endfunction

    function automatic void model_update(input int s, input bit hit, input int hw, input int fill);
        bit found;
        if (hit) model[s][hw] = (model[s][hw] >= 2) ? 1 : 0;
        else model[s][fill] = 1;
        // Raise one step at a time until some way reaches 3
        found = 0;
        while (!found) begin
            for (int w = 0; w < NW; w++) if (model[s][w] == 3) found = 1;
            if (!found) for (int w = 0; w < NW; w++) model[s][w] = model[s][w] + 1;
        end
    endfunction

    // One access, checking the victim on misses
    task automatic access(input int s, input bit hit, input int hw, input string req);
        int exp;
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_set     = 4'(s);
        acc_hit     = hit;
        acc_hit_way = 4'(hw);
        way_valid   = vmask[s];
        #1;
        exp = model_victim(s);
        if (!hit) check(req, int'(victim_way), exp);
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        model_update(s, hit, hw, exp);
        if (!hit) vmask[s][exp] = 1'b1;
    endtask

    // Look at the victim of a set without a strobe
    task automatic peek(input int s, input logic [NW-1:0] mask, input int exp, input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_set   = 4'(s);
        way_valid = mask;
        #1;
        check(req, int'(victim_way), exp);
    endtask

    task automatic test_reset;
        for (int s = 0; s < NS; s++) peek(s, '1, 0, "R1");
        peek(2, '0, 0, "R1");
    endtask

    task automatic test_fill_empty;
        vmask[3] = '0;
        for (int i = 0; i < NW; i++) access(3, 1'b0, 0, "R2");
        peek(3, 16'hFFDF, 5, "R2");
        peek(3, 16'h7FFF, 15, "R2");
        access(3, 1'b0, 0, "R3");
    endtask

    task automatic test_evict_order;
        vmask[5] = '1;
        access(5, 1'b0, 0, "R3");
        access(5, 1'b0, 0, "R4");
        access(5, 1'b0, 0, "R4");
        peek(5, '1, 3, "R3");
    endtask

    task automatic test_promote;
        vmask[7] = '1;
        access(7, 1'b0, 0, "R4");
        access(7, 1'b1, 0, "R5");
        access(7, 1'b1, 0, "R5");
        for (int i = 1; i < NW; i++) access(7, 1'b0, 0, "R6");
        // Way 0 stood at 0 and the rest at 1, so the raise leaves way 0 at 2
        peek(7, '1, 1, "R6");
        access(7, 1'b1, 3, "R5");
        peek(7, '1, 1, "R5");
    endtask

    task automatic test_isolation;
        vmask[9] = '1;
        vmask[10] = '1;
        access(10, 1'b0, 0, "R7");
        for (int i = 0; i < 4; i++) access(9, 1'b0, 0, "R7");
        peek(10, '1, model_victim(10), "R7");
        check("R7", model_victim(10), 1);
    endtask

    task automatic test_idle;
        vmask[6] = '1;
        access(6, 1'b0, 0, "R8");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            acc_valid   = 1'b0;
            acc_set     = 4'(6);
            acc_hit     = 1'b0;
            acc_hit_way = 4'(i);
            way_valid   = 16'h0000;
        end
        peek(6, '1, 1, "R8");
    endtask

    task automatic test_mixed;
        logic [15:0] lfsr = 16'hACE1;
        for (int s = 11; s < NS; s++) vmask[s] = '1;
        for (int i = 0; i < 1500; i++) begin
            int s, hw;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s  = 11 + (int'(lfsr[3:0]) % 5);
            hw = int'(lfsr[11:8]);
            access(s, lfsr[6] & lfsr[5], hw, "R6");
        end
        for (int s = 11; s < NS; s++) peek(s, '1, model_victim(s), "R3");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            vmask[s] = '0;
            for (int w = 0; w < NW; w++) model[s][w] = 3;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        test_reset();
        test_fill_empty();
        test_evict_order();
        test_promote();
        test_isolation();
        test_idle();
        test_mixed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule